// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides which hardware thread the instruction fetch stage serves next. It supports up to eight threads. Each thread reports a 4-bit fetch state code, an instruction-queue occupancy count and a load/store-queue occupancy count. An active mask and a static policy code steer the choice. A thread can be picked only when its state code says it is able to fetch.

The selector offers `NUM_SLOTS` grant slots per cycle, so the stage can fetch from several threads in one cycle. Slot 0 is the first choice. Each later slot takes the best remaining thread, leaving out threads already granted in earlier slots that cycle. Once a slot finds nothing, every later slot is empty too, so the stage stops trying threads for that cycle.

The supported policies are:
- a fixed single-thread choice,
- a rotating order that sends granted threads to the back of the line,
- two occupancy-driven choices.

The grant outputs are combinational, decoded from the current inputs and the rotation state. They are plain control pins with no handshake: the consumer either uses the grant in the cycle it appears or ignores it. No back-pressure path exists. The only register is the rotation order, which changes at the clock edge after a granting rotation cycle.

Top module: `fts_thread_select`

## Requirements
- R1: A thread is able to fetch only when its state code is 0 (running), 1 (idle) or 4 (line filled). Codes 2, 3, 5, 6, 7, 8 and 9 to 15 make it unable to fetch.
- R2: Under the rotation policy (code 1), slot 0 grants the first able thread in the order list, counting from the head. Each later slot grants the next able thread in list order that has not yet been granted this cycle. The active mask is not consulted.
- R3: After a cycle with `pick_en` high, rotation policy and at least one grant, the order list changes at the clock edge. The granted threads are moved to the tail in slot order, and all other entries keep their relative order. In every other cycle the list is unchanged.
- R4: The synchronous reset (`rst_n` low at a clock edge) sets the order list to ascending thread index, with thread 0 at the head.
- R5: With `pick_en` low, no slot grants. If a slot gives no grant, all higher slots give no grant.
- R6: With more than one thread configured, the single-thread policy (code 0) grants thread 0 in slot 0 whatever its state or mask bit. The other slots give no grant.
- R7: Under the instruction-queue policy (code 3), each slot grants the highest instruction-queue count among threads that are active, able to fetch and not granted in an earlier slot. A tie goes to the lower thread index.
- R8: Under the load/store-queue policy (code 4), the same selection as R7 applies, using the load/store-queue counts.
- R9: With more than one thread configured, the branch-count policy (code 2) and the unused codes 5, 6 and 7 give no grant.
- R10: With one thread configured, the policy code is ignored. Slot 0 grants thread 0 exactly when `pick_en` is high, its active bit is set and it is able to fetch. Other slots never grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the order list |
| pick_en | input | 1 | The fetch stage asks for grants this cycle |
| policy | input | 3 | Selection policy code |
| thread_active | input | NUM_THREADS | Active-thread mask |
| thread_status | input | NUM_THREADS*4 | Per-thread fetch state codes, thread t at bits [4t+3:4t] |
| iq_count | input | NUM_THREADS*CNT_W | Per-thread instruction-queue occupancy |
| lsq_count | input | NUM_THREADS*CNT_W | Per-thread load/store-queue occupancy |
| grant_valid | output | NUM_SLOTS | Per-slot grant flag |
| grant_tid | output | NUM_SLOTS*TID_W | Per-slot granted thread index |

## Verification
Two functions can meet in one cycle:
- **Several grants plus a rotation.** Under rotation, two slots can grant while the order list is rebuilt at the following edge, so two threads move to the tail together and their order there matters. The bench provokes this with long pseudo-random runs of state codes in which several threads are often able to fetch. It checks each slot against a model list kept in the bench and updated with the same tail rule, so a wrong rebuild shows up as a wrong grant in a later cycle.
- **Synchronous reset against rotation.** Reset is applied directly after rotation cycles, and the next grants must come out in ascending order.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int ST_W = 4;

  localparam logic [ST_W-1:0] ST_RUN        = 4'd0;
  localparam logic [ST_W-1:0] ST_IDLE       = 4'd1;
  localparam logic [ST_W-1:0] ST_SQUASH     = 4'd2;
  localparam logic [ST_W-1:0] ST_BLOCK      = 4'd3;
  localparam logic [ST_W-1:0] ST_FILLED     = 4'd4;
  localparam logic [ST_W-1:0] ST_WAIT_RESP  = 4'd5;
  localparam logic [ST_W-1:0] ST_WAIT_RETRY = 4'd6;
  localparam logic [ST_W-1:0] ST_TRAP       = 4'd7;
  localparam logic [ST_W-1:0] ST_QUIESCE    = 4'd8;

  localparam int POL_W = 3;
  localparam logic [POL_W-1:0] POL_SOLO   = 3'd0;
  localparam logic [POL_W-1:0] POL_ROTATE = 3'd1;
  localparam logic [POL_W-1:0] POL_BRANCH = 3'd2;
  localparam logic [POL_W-1:0] POL_IQ     = 3'd3;
  localparam logic [POL_W-1:0] POL_LSQ    = 3'd4;

  // R1: only these three states may be served
  function automatic logic can_fetch(input logic [ST_W-1:0] s);
    return (s == ST_RUN) || (s == ST_IDLE) || (s == ST_FILLED);
  endfunction
endpackage

// File: rtl/fts_rr_order.sv
module fts_rr_order #(
  parameter int NT    = 8,
  parameter int NS    = 2,
  parameter int TID_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      advance,
  input  logic [NT-1:0]             elig,
  output logic [NS-1:0]             gnt_v,
  output logic [NS-1:0][TID_W-1:0]  gnt_id
);
  logic [NT-1:0][TID_W-1:0] order_q, order_d;
  logic [NT-1:0]            taken;
  logic [NT-1:0]            present;
  int                       fill_idx;

  // scan positions from the head; each slot takes the next able entry
  always_comb begin
    taken  = '0;
    gnt_v  = '0;
    gnt_id = '0;
    for (int s = 0; s < NS; s++) begin
      for (int p = 0; p < NT; p++) begin
        if (!gnt_v[s] && !taken[p] && elig[order_q[p]]) begin
          gnt_v[s]  = 1'b1;
          gnt_id[s] = order_q[p];
          taken[p]  = 1'b1;
        end
      end
    end
  end

  // survivors keep their order, granted threads follow in slot order
  always_comb begin
    order_d  = order_q;
    fill_idx = 0;
    for (int p = 0; p < NT; p++) begin
      if (!taken[p]) begin
        order_d[fill_idx[TID_W-1:0]] = order_q[p];
        fill_idx = fill_idx + 1;
      end
    end
    for (int s = 0; s < NS; s++) begin
      if (gnt_v[s]) begin
        order_d[fill_idx[TID_W-1:0]] = gnt_id[s];
        fill_idx = fill_idx + 1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) order_q[i] <= TID_W'(i);
    end else if (advance && (|gnt_v)) begin
      order_q <= order_d;
    end
  end

  always_comb begin
    present = '0;
    for (int p = 0; p < NT; p++) present[order_q[p]] = 1'b1;
  end

  assert_perm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    present == {NT{1'b1}});
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(advance && (|gnt_v)) |=> $stable(order_q));
  assert_reset_head_R4: assert property (@(posedge clk)
    !rst_n |=> (order_q[0] == '0));
endmodule

// File: rtl/fts_occ_pick.sv
module fts_occ_pick #(
  parameter int NT    = 8,
  parameter int NS    = 2,
  parameter int TID_W = 3,
  parameter int CNT_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NT-1:0]             cand,
  input  logic [NT-1:0][CNT_W-1:0]  cnt,
  output logic [NS-1:0]             gnt_v,
  output logic [NS-1:0][TID_W-1:0]  gnt_id
);
  logic [NT-1:0]    taken;
  logic [CNT_W-1:0] best_c;
  logic             beaten;

  // strict greater-than keeps the lower index on a tie
  always_comb begin
    taken  = '0;
    gnt_v  = '0;
    gnt_id = '0;
    best_c = '0;
    for (int s = 0; s < NS; s++) begin
      best_c = '0;
      for (int t = 0; t < NT; t++) begin
        if (cand[t] && !taken[t] && (!gnt_v[s] || cnt[t] > best_c)) begin
          gnt_v[s]  = 1'b1;
          gnt_id[s] = TID_W'(t);
          best_c    = cnt[t];
        end
      end
      if (gnt_v[s]) taken[gnt_id[s]] = 1'b1;
    end
  end

  always_comb begin
    beaten = 1'b0;
    for (int t = 0; t < NT; t++)
      if (cand[t] && cnt[t] > cnt[gnt_id[0]]) beaten = 1'b1;
  end

  assert_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_v[0] |-> (!beaten && cand[gnt_id[0]]));
  assert_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cand == '0) |-> (gnt_v == '0));
  assert_some_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cand != '0) |-> gnt_v[0]);
endmodule

// File: rtl/fts_thread_select.sv
module fts_thread_select
  import fts_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int NUM_SLOTS   = 2,
  parameter int CNT_W       = 6,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pick_en,
  input  logic [POL_W-1:0]              policy,
  input  logic [NUM_THREADS-1:0]        thread_active,
  input  logic [NUM_THREADS*ST_W-1:0]   thread_status,
  input  logic [NUM_THREADS*CNT_W-1:0]  iq_count,
  input  logic [NUM_THREADS*CNT_W-1:0]  lsq_count,
  output logic [NUM_SLOTS-1:0]          grant_valid,
  output logic [NUM_SLOTS*TID_W-1:0]    grant_tid
);
  logic [NUM_THREADS-1:0]           elig;
  logic [NUM_SLOTS-1:0]             sel_v;
  logic [NUM_SLOTS-1:0][TID_W-1:0]  sel_id;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_elig
    assign elig[t] = can_fetch(thread_status[t*ST_W +: ST_W]);
  end

  if (NUM_THREADS == 1) begin : g_one
    // R10: policy ignored
    always_comb begin
      sel_v    = '0;
      sel_id   = '0;
      sel_v[0] = pick_en && thread_active[0] && elig[0];
    end

    assert_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid[0] |-> (thread_active[0] && elig[0]));
  end else begin : g_multi
    logic [NUM_SLOTS-1:0]                rr_v, oc_v;
    logic [NUM_SLOTS-1:0][TID_W-1:0]     rr_id, oc_id;
    logic [NUM_THREADS-1:0][CNT_W-1:0]   occ_cnt;
    logic                                rr_adv;

    assign rr_adv = pick_en && (policy == POL_ROTATE);

    always_comb begin
      for (int t = 0; t < NUM_THREADS; t++)
        occ_cnt[t] = (policy == POL_LSQ) ? lsq_count[t*CNT_W +: CNT_W]
                                         : iq_count[t*CNT_W +: CNT_W];
    end

    fts_rr_order #(.NT(NUM_THREADS), .NS(NUM_SLOTS), .TID_W(TID_W)) rr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (rr_adv),
      .elig    (elig),
      .gnt_v   (rr_v),
      .gnt_id  (rr_id)
    );

    fts_occ_pick #(.NT(NUM_THREADS), .NS(NUM_SLOTS), .TID_W(TID_W),
                   .CNT_W(CNT_W)) occ_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .cand   (elig & thread_active),
      .cnt    (occ_cnt),
      .gnt_v  (oc_v),
      .gnt_id (oc_id)
    );

    always_comb begin
      sel_v  = '0;
      sel_id = '0;
      if (pick_en) begin
        case (policy)
          POL_SOLO:       sel_v[0] = 1'b1;
          POL_ROTATE:     begin sel_v = rr_v; sel_id = rr_id; end
          POL_IQ, POL_LSQ: begin sel_v = oc_v; sel_id = oc_id; end
          default:        ;
        endcase
      end
    end

    assert_nogrant_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (policy == POL_BRANCH || policy > POL_LSQ) |-> (grant_valid == '0));
    assert_solo_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pick_en && policy == POL_SOLO) |->
        (grant_valid[0] && grant_tid[TID_W-1:0] == '0));

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot_chk
      assert_elig_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid[s] && policy != POL_SOLO) |->
          elig[grant_tid[s*TID_W +: TID_W]]);
      if (s > 0) begin : g_later
        assert_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
          grant_valid[s] |-> grant_valid[s-1]);
        assert_distinct_R2: assert property (@(posedge clk) disable iff (!rst_n)
          grant_valid[s] |->
            (grant_tid[s*TID_W +: TID_W] != grant_tid[(s-1)*TID_W +: TID_W]));
      end
    end
  end

  assign grant_valid = sel_v;
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_pack
    assign grant_tid[s*TID_W +: TID_W] = sel_id[s];
  end

  assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_en |-> (grant_valid == '0));
endmodule

// File: tb/fts_thread_select_tb_top.sv
`timescale 1ns/1ps
module fts_thread_select_tb_top;
  localparam int NT = 4;
  localparam int NS = 2;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic pick;
  logic [2:0] policy;
  logic [NT-1:0] active;
  logic [NT*4-1:0] status;
  logic [NT*CW-1:0] iqc, lsqc;
  logic [NS-1:0] g_v;
  logic [NS*2-1:0] g_id;

  logic [3:0] st1;
  logic a1;
  logic [CW-1:0] iq1, lsq1;
  logic [NS-1:0] g1_v;
  logic [NS-1:0] g1_id;

  int checks = 0;
  int fails = 0;
  int order_m[NT];
  int exp_v[NS], exp_id[NS];
  bit rr_tk[NT];
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  fts_thread_select #(.NUM_THREADS(NT), .NUM_SLOTS(NS), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pick_en(pick), .policy(policy),
    .thread_active(active), .thread_status(status),
    .iq_count(iqc), .lsq_count(lsqc),
    .grant_valid(g_v), .grant_tid(g_id));

  fts_thread_select #(.NUM_THREADS(1), .NUM_SLOTS(NS), .CNT_W(CW)) dut1_i (
    .clk(clk), .rst_n(rst_n), .pick_en(pick), .policy(policy),
    .thread_active(a1), .thread_status(st1),
    .iq_count(iq1), .lsq_count(lsq1),
    .grant_valid(g1_v), .grant_tid(g1_id));

  function automatic int unsigned rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic bit able(int c);
    return (c == 0) || (c == 1) || (c == 4);
  endfunction

  function automatic int st_of(int t);
    return int'(status[t*4 +: 4]);
  endfunction

  function automatic int cnt_of(int t);
    return (policy == 3'd4) ? int'(lsqc[t*CW +: CW]) : int'(iqc[t*CW +: CW]);
  endfunction

  task automatic reset_model();
    for (int i = 0; i < NT; i++) order_m[i] = i;
  endtask

  task automatic model_compute();
    bit tk[NT];
    int best, bc;
    for (int s = 0; s < NS; s++) begin exp_v[s] = 0; exp_id[s] = 0; end
    for (int p = 0; p < NT; p++) begin rr_tk[p] = 0; tk[p] = 0; end
    if (pick) begin
      case (policy)
        3'd0: exp_v[0] = 1;
        3'd1: begin
          for (int s = 0; s < NS; s++)
            for (int p = 0; p < NT; p++)
              if (exp_v[s] == 0 && !rr_tk[p] && able(st_of(order_m[p]))) begin
                exp_v[s] = 1; exp_id[s] = order_m[p]; rr_tk[p] = 1;
              end
        end
        3'd3, 3'd4: begin
          for (int s = 0; s < NS; s++) begin
            best = -1; bc = 0;
            for (int t = 0; t < NT; t++)
              if (active[t] && able(st_of(t)) && !tk[t] && (best < 0 || cnt_of(t) > bc)) begin
                best = t; bc = cnt_of(t);
              end
            if (best >= 0) begin exp_v[s] = 1; exp_id[s] = best; tk[best] = 1; end
          end
        end
        default: ;
      endcase
    end
  endtask

  task automatic model_commit();
    int nl[NT];
    int k;
    if (pick && policy == 3'd1 && exp_v[0] == 1) begin
      k = 0;
      for (int p = 0; p < NT; p++) if (!rr_tk[p]) begin nl[k] = order_m[p]; k++; end
      for (int s = 0; s < NS; s++) if (exp_v[s] == 1) begin nl[k] = exp_id[s]; k++; end
      for (int p = 0; p < NT; p++) order_m[p] = nl[p];
    end
  endtask

  // inputs were driven just after a negedge
  task automatic run_cycle(string tag);
    int gid;
    #2;
    model_compute();
    for (int s = 0; s < NS; s++) begin
      gid = int'(g_id[s*2 +: 2]);
      checks++;
      if (int'(g_v[s]) != exp_v[s] || (exp_v[s] == 1 && gid != exp_id[s])) begin
        fails++;
        $display("FAIL %s slot%0d pol=%0d: got v=%0d id=%0d expected v=%0d id=%0d",
                 tag, s, policy, g_v[s], gid, exp_v[s], exp_id[s]);
      end
    end
    model_commit();
    @(negedge clk);
  endtask

  function automatic string pol_tag();
    case (policy)
      3'd0: return "R6";
      3'd1: return pick ? "R2 R3" : "R5";
      3'd3: return "R7";
      3'd4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic rand_status();
    for (int t = 0; t < NT; t++) begin
      int unsigned r = rnd();
      if (r[4]) status[t*4 +: 4] = (r[1:0] == 2'd0) ? 4'd0 : (r[1:0] == 2'd1) ? 4'd1 : 4'd4;
      else status[t*4 +: 4] = 4'(r[11:8]);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; pick = 1'b0; policy = 3'd1; active = '1;
    status = '0; iqc = '0; lsqc = '0;
    st1 = 4'd3; a1 = 1'b0; iq1 = '0; lsq1 = '0;
    reset_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R5: no request, no grant; R4: ascending order after reset
    run_cycle("R5");
    pick = 1'b1;
    run_cycle("R4");

    // R1: every state code on thread 0 alone
    policy = 3'd3; active = 4'b0001;
    for (int c = 0; c < 16; c++) begin
      status = {4'd3, 4'd3, 4'd3, 4'(c)};
      run_cycle("R1");
    end

    // R2 R3: rotation with several able threads
    policy = 3'd1; active = '1;
    for (int i = 0; i < 400; i++) begin
      rand_status();
      pick = (rnd() % 8) != 0;
      active = 4'(rnd());
      run_cycle(pol_tag());
    end

    // R4: synchronous reset right after rotation
    pick = 1'b1; status = '0;
    run_cycle("R3");
    run_cycle("R3");
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    reset_model();
    run_cycle("R4");

    // R7 R8: occupancy policies
    for (int i = 0; i < 1500; i++) begin
      rand_status();
      policy = (rnd() % 2 == 0) ? 3'd3 : 3'd4;
      active = 4'(rnd());
      iqc = 12'(rnd()); lsqc = 12'(rnd());
      if (i % 5 == 0) iqc = {3'd5, 3'd5, 3'd5, 3'd5};
      pick = 1'b1;
      run_cycle(pol_tag());
    end

    // mixed: every policy code, rotation state must survive the others
    for (int i = 0; i < 1500; i++) begin
      rand_status();
      policy = 3'(rnd());
      active = 4'(rnd());
      iqc = 12'(rnd()); lsqc = 12'(rnd());
      pick = (rnd() % 6) != 0;
      run_cycle(pol_tag());
    end

    // R10: one-thread configuration, main instance kept from rotating
    status = {4{4'd3}};
    pick = 1'b1;
    for (int c = 0; c < 16; c++)
      for (int a = 0; a < 2; a++)
        for (int p = 0; p < 8; p++) begin
          int ev;
          st1 = 4'(c); a1 = a[0]; policy = 3'(p);
          #2;
          ev = (a == 1 && able(c)) ? 1 : 0;
          checks++;
          if (int'(g1_v[0]) != ev || (ev == 1 && g1_id[0] != 1'b0)) begin
            fails++;
            $display("FAIL R10 slot0: got v=%0d id=%0d expected v=%0d id=0",
                     g1_v[0], g1_id[0], ev);
          end
          checks++;
          if (g1_v[1] != 1'b0) begin
            fails++;
            $display("FAIL R10 slot1: got v=%0d expected v=0", g1_v[1]);
          end
          @(negedge clk);
        end

    finish_run();
  end
endmodule